// File: doc/BRIEF.md
# Paged Memory Mapper with Page-Class Waitstates

This block sits between a 16-bit CPU and a 2 MiB physical memory space. It splits the 64 KiB logical space into eight 8 KiB regions. Each region takes its physical page from its own 8-bit page register. The physical address is the selected page followed by the low 13 logical address bits.

Each external access takes one cycle plus a wait count. The wait count depends on the class of the physical page: a small set of fast pages needs no wait, and every other page needs one. An extra-waitstate input adds one more cycle to every external access. A 256-byte window for on-chip RAM is never translated and never delayed.

An emulation mode changes two things. The page registers can also be written through a memory-mapped window. The cartridge region is locked to a fixed pair of pages, and a write into that region selects which page of the pair is used.

Top module: `page_mapper`

## Requirements
- R1: After reset the page registers for regions 0..7 hold 0xEC, 0xED, 0x07, 0x36, 0xEE, 0xEF, 0x03, 0x35. The outputs idle with ready=1, ext_en=0 and phys_addr=0.
- R2: The region is logical address bits [15:13]. An accepted external access latches phys_addr = {page[7:0], addr[12:0]} at the clock edge that accepts it, and phys_addr holds that value while ext_en is high.
- R3: A pulse on reg_we loads reg_wdata into register reg_idx in either mode. The new page applies to the next access.
- R4: In emulation mode (emu_mode=1), a write access (acc_we=1) to 0x8000-0x8007 loads acc_wdata into register addr[2:0] and starts no external access. In native mode the same address is an ordinary external access in region 4 and changes no register.
- R5: In emulation mode, region 3 (0x6000-0x7FFF) translates to page 0x36 when the cartridge bank is 0 and 0x37 when it is 1, whatever register 3 holds. In native mode region 3 uses register 3.
- R6: In emulation mode, a write access into region 3 sets the cartridge bank to addr[1], which takes effect from the next access. The write itself is translated with the previous bank. The bank resets to 0.
- R7: Pages 0xEC-0xEF need 0 waits and all other pages need 1 wait. After the accepting edge, ready is low for exactly the wait count of cycles and ext_en is high for 1 + wait count cycles.
- R8: When extra_wait_en=1, every external access gets one more wait cycle.
- R9: For addresses 0xF000-0xF0FF, onchip_hit follows acc_valid in the same cycle. No external access starts and ready stays high, whatever register 7 holds. Address 0xF100 is an ordinary region-7 access.
- R10: An acc_valid that arrives while ready is low is ignored: phys_addr is unchanged and no further access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| extra_wait_en | input | 1 | Adds one wait cycle to every external access |
| acc_valid | input | 1 | CPU access request, accepted while ready is high |
| acc_addr | input | 16 | Logical address |
| acc_we | input | 1 | Access is a write |
| acc_wdata | input | 8 | Write data, used for memory-mapped register writes |
| reg_we | input | 1 | Direct page register write strobe |
| reg_idx | input | 3 | Direct page register index |
| reg_wdata | input | 8 | Direct page register value |
| phys_addr | output | 21 | Latched physical address of the current access |
| ext_en | output | 1 | External access in progress |
| ready | output | 1 | Low while the CPU must wait |
| onchip_hit | output | 1 | Request falls in the on-chip RAM window |

## Verification
The hardest case to reach is a request that arrives while the mapper is still stretching an earlier access. A lost or wrongly accepted access only shows up in the cycles after that earlier access ends. The bench gets there by turning on the extra waitstate, so a slow page gives two wait cycles. It then raises acc_valid for a fast-page address in the first low-ready cycle. Afterwards it confirms that phys_addr did not move and that ext_en drops exactly when the first access ends. A second subtle case is the cartridge bank write: the bench checks that the write still uses the old page and that only the following read sees the new one.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned LADDR_W = 16;
  localparam int unsigned OFF_W   = 13;
  localparam int unsigned PAGE_W  = 8;
  localparam int unsigned RGN_W   = LADDR_W - OFF_W;
  localparam int unsigned NRGN    = 1 << RGN_W;
  localparam int unsigned PADDR_W = PAGE_W + OFF_W;
  localparam int unsigned WAIT_W  = 2;

  typedef logic [PAGE_W-1:0] page_t;

  function automatic page_t boot_page(input int unsigned idx);
    case (idx)
      0: boot_page = 8'hEC;
      1: boot_page = 8'hED;
      2: boot_page = 8'h07;
      3: boot_page = 8'h36;
      4: boot_page = 8'hEE;
      5: boot_page = 8'hEF;
      6: boot_page = 8'h03;
      default: boot_page = 8'h35;
    endcase
  endfunction

  function automatic logic page_is_fast(input page_t p);
    page_is_fast = (p[PAGE_W-1:2] == 6'b111011);
  endfunction
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [RGN_W-1:0]            wr_idx,
  input  page_t                       wr_data,
  input  logic                        bank_we,
  input  logic                        bank_val,
  output page_t [NRGN-1:0]            pages,
  output logic                        bank
);
  logic bank_d;

  for (genvar i = 0; i < NRGN; i++) begin : g_reg
    page_t page_d;
    always_comb begin
      page_d = pages[i];
      if (wr_en && (wr_idx == RGN_W'(i))) page_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pages[i] <= boot_page(i);
      else        pages[i] <= page_d;
    end
  end

  always_comb begin
    bank_d = bank;
    if (bank_we) bank_d = bank_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank <= 1'b0;
    else        bank <= bank_d;
  end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter logic [LADDR_W-1:0] REG_WIN  = 16'h8000,
  parameter logic [LADDR_W-1:0] BYP_LO   = 16'hF000,
  parameter logic [LADDR_W-1:0] BYP_HI   = 16'hF0FF,
  parameter page_t              CART_PG  = 8'h36,
  parameter int unsigned        CART_RGN = 3
) (
  input  logic                 emu_mode,
  input  logic [LADDR_W-1:0]   addr,
  input  page_t [NRGN-1:0]     pages,
  input  logic                 bank,
  output page_t                page,
  output logic                 fast,
  output logic                 bypass,
  output logic                 reg_hit,
  output logic                 cart_hit
);
  logic [RGN_W-1:0] rgn;

  always_comb begin
    rgn      = addr[LADDR_W-1:OFF_W];
    cart_hit = emu_mode && (rgn == RGN_W'(CART_RGN));
    page     = cart_hit ? {CART_PG[PAGE_W-1:1], bank} : pages[rgn];
    fast     = page_is_fast(page);
    bypass   = (addr >= BYP_LO) && (addr <= BYP_HI);
    reg_hit  = emu_mode && (addr[LADDR_W-1:RGN_W] == REG_WIN[LADDR_W-1:RGN_W]);
  end
endmodule

// File: rtl/mapper_wait.sv
module mapper_wait
  import mapper_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WAIT_W-1:0]    waits,
  input  logic [PADDR_W-1:0]   phys_in,
  output logic                 ready,
  output logic                 ext_en,
  output logic [PADDR_W-1:0]   phys_q
);
  logic [WAIT_W-1:0]  rem_q, rem_d;
  logic [PADDR_W-1:0] phys_d;

  always_comb begin
    rem_d  = rem_q;
    phys_d = phys_q;
    if (start) begin
      rem_d  = waits + WAIT_W'(1);
      phys_d = phys_in;
    end else if (rem_q != '0) begin
      rem_d = rem_q - WAIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      phys_q <= '0;
    end else begin
      rem_q  <= rem_d;
      phys_q <= phys_d;
    end
  end

  assign ready  = (rem_q <= WAIT_W'(1));
  assign ext_en = (rem_q != '0);

  p_zero_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && (waits == '0) |=> ready && ext_en);
  p_wait_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && (waits != '0) |=> !ready && ext_en);
  p_phys_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(phys_q));
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import mapper_pkg::*;
#(
  parameter logic [15:0] REG_WIN = 16'h8000,
  parameter logic [15:0] BYP_LO  = 16'hF000,
  parameter logic [15:0] BYP_HI  = 16'hF0FF,
  parameter logic [7:0]  CART_PG = 8'h36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        emu_mode,
  input  logic        extra_wait_en,
  input  logic        acc_valid,
  input  logic [15:0] acc_addr,
  input  logic        acc_we,
  input  logic [7:0]  acc_wdata,
  input  logic        reg_we,
  input  logic [2:0]  reg_idx,
  input  logic [7:0]  reg_wdata,
  output logic [20:0] phys_addr,
  output logic        ext_en,
  output logic        ready,
  output logic        onchip_hit
);
  localparam int unsigned CART_RGN = 3;

  logic [1:0]        rst_sync;
  logic              rst_s;
  page_t [NRGN-1:0]  pages;
  logic              bank;
  page_t             page;
  logic              fast, bypass, reg_hit, cart_hit;
  logic              take, start, mm_wr, wr_en, bank_we;
  logic [RGN_W-1:0]  wr_idx;
  page_t             wr_data;
  logic [WAIT_W-1:0] waits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  mapper_xlate #(
    .REG_WIN(REG_WIN), .BYP_LO(BYP_LO), .BYP_HI(BYP_HI),
    .CART_PG(CART_PG), .CART_RGN(CART_RGN)
  ) u_xlate (
    .emu_mode(emu_mode), .addr(acc_addr), .pages(pages), .bank(bank),
    .page(page), .fast(fast), .bypass(bypass), .reg_hit(reg_hit),
    .cart_hit(cart_hit)
  );

  always_comb begin
    take    = acc_valid && ready && !bypass;
    mm_wr   = take && acc_we && reg_hit;
    start   = take && !mm_wr;
    bank_we = take && acc_we && cart_hit;
    wr_en   = reg_we || mm_wr;
    wr_idx  = reg_we ? reg_idx : acc_addr[RGN_W-1:0];
    wr_data = reg_we ? reg_wdata : acc_wdata;
    waits   = {1'b0, !fast} + {1'b0, extra_wait_en};
  end

  assign onchip_hit = acc_valid && bypass;

  mapper_regs u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .bank_we(bank_we), .bank_val(acc_addr[1]),
    .pages(pages), .bank(bank)
  );

  mapper_wait u_wait (
    .clk(clk), .rst_n(rst_s), .start(start), .waits(waits),
    .phys_in({page, acc_addr[OFF_W-1:0]}), .ready(ready),
    .ext_en(ext_en), .phys_q(phys_addr)
  );

  p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s)
    onchip_hit && ready |=> ready && !ext_en);
  p_cart_lock_r5: assert property (@(posedge clk) disable iff (!rst_s)
    emu_mode && acc_valid && ready && cart_hit && !bypass
      |=> phys_addr[20:14] == CART_PG[7:1]);
  p_regwin_no_ext_r4: assert property (@(posedge clk) disable iff (!rst_s)
    mm_wr |=> !ext_en);
  p_extra_wait_r8: assert property (@(posedge clk) disable iff (!rst_s)
    start && extra_wait_en |=> !ready);
endmodule

// File: tb/tb_page_mapper.sv
module tb_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        emu_mode = 1'b0, extra_wait_en = 1'b0;
  logic        acc_valid = 1'b0, acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic [20:0] phys_addr;
  logic        ext_en, ready, onchip_hit;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_mapper dut (
    .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .extra_wait_en(extra_wait_en),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .phys_addr(phys_addr), .ext_en(ext_en), .ready(ready), .onchip_hit(onchip_hit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fastw(input int pg);
    return (pg >= 'hEC && pg <= 'hEF) ? 0 : 1;
  endfunction

  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] d,
                        output int phys, output int ext, output int w);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_we = we; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
    phys = int'(phys_addr); ext = int'(ext_en); w = 0;
    while (!ready && w < 8) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic poke(input int idx, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = 8'(val);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic t_reset();
    int p, e, w;
    int boot[8] = '{'hEC, 'hED, 'h07, 'h36, 'hEE, 'hEF, 'h03, 'h35};
    check("R1 idle ready", int'(ready), 1);
    check("R1 idle ext_en", int'(ext_en), 0);
    check("R1 idle phys", int'(phys_addr), 0);
    for (int i = 0; i < 8; i++) begin
      access(16'(i * 'h2000 + 'h0123), 1'b0, 8'h00, p, e, w);
      check("R1 R2 boot page translate", p, (boot[i] << 13) | 'h0123);
      check("R7 page wait count", w, fastw(boot[i]));
      check("R7 ext_en during access", e, 1);
    end
    @(negedge clk);
    check("R7 ext_en ends", int'(ext_en), 0);
  endtask

  task automatic t_direct_write();
    int p, e, w;
    poke(1, 'h44);
    access(16'h2ABC, 1'b0, 8'h00, p, e, w);
    check("R3 direct write page", p, ('h44 << 13) | 'h0ABC);
    check("R7 slow page wait", w, 1);
    poke(6, 'hED);
    access(16'hC001, 1'b0, 8'h00, p, e, w);
    check("R3 direct write fast page", p, ('hED << 13) | 'h0001);
    check("R7 fast page no wait", w, 0);
  endtask

  task automatic t_extra();
    int p, e, w;
    extra_wait_en = 1'b1;
    access(16'h0000, 1'b0, 8'h00, p, e, w);
    check("R8 extra on fast page", w, 1);
    access(16'h4000, 1'b0, 8'h00, p, e, w);
    check("R8 extra on slow page", w, 2);
    extra_wait_en = 1'b0;
  endtask

  task automatic t_emu_regs();
    int p, e, w;
    emu_mode = 1'b1;
    access(16'h8002, 1'b1, 8'hBA, p, e, w);
    check("R4 reg window write no ext", e, 0);
    check("R4 reg window write no wait", w, 0);
    access(16'h4010, 1'b0, 8'h00, p, e, w);
    check("R4 reg window wrote region 2", p, ('hBA << 13) | 'h0010);
    emu_mode = 1'b0;
    access(16'h8002, 1'b1, 8'h11, p, e, w);
    check("R4 native 8002 is external", e, 1);
    check("R4 native 8002 region 4 page", p, ('hEE << 13) | 'h0002);
    access(16'h4000, 1'b0, 8'h00, p, e, w);
    check("R4 native write left reg 2", p, 'hBA << 13);
  endtask

  task automatic t_cart();
    int p, e, w;
    emu_mode = 1'b1;
    access(16'h8003, 1'b1, 8'hEC, p, e, w);
    access(16'h6000, 1'b0, 8'h00, p, e, w);
    check("R5 cart locked bank0", p, 'h36 << 13);
    check("R5 R7 cart page slow", w, 1);
    access(16'h6002, 1'b1, 8'h00, p, e, w);
    check("R6 bank write uses old bank", p, ('h36 << 13) | 'h0002);
    access(16'h7000, 1'b0, 8'h00, p, e, w);
    check("R6 bank1 selected", p, ('h37 << 13) | 'h1000);
    access(16'h6000, 1'b1, 8'h00, p, e, w);
    access(16'h6004, 1'b0, 8'h00, p, e, w);
    check("R6 bank0 selected", p, ('h36 << 13) | 'h0004);
    emu_mode = 1'b0;
    access(16'h6000, 1'b0, 8'h00, p, e, w);
    check("R5 native uses reg 3", p, 'hEC << 13);
    check("R5 native reg 3 fast", w, 0);
  endtask

  task automatic t_bypass();
    int p, e, w;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = (k == 0) ? 16'hF000 : 16'hF0FF;
      #1 check("R9 onchip_hit same cycle", int'(onchip_hit), 1);
      @(negedge clk);
      acc_valid = 1'b0;
      check("R9 bypass no ext", int'(ext_en), 0);
      check("R9 bypass ready", int'(ready), 1);
    end
    access(16'hF100, 1'b0, 8'h00, p, e, w);
    check("R9 F100 translated", p, ('h35 << 13) | 'h1100);
    check("R9 F100 slow wait", w, 1);
    poke(7, 'hEE);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 16'hF080;
    #1 check("R9 bypass with reg7 changed", int'(onchip_hit), 1);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R9 bypass reg7 no ext", int'(ext_en), 0);
    access(16'hF100, 1'b0, 8'h00, p, e, w);
    check("R9 F100 new reg7", p, ('hEE << 13) | 'h1100);
  endtask

  task automatic t_busy();
    extra_wait_en = 1'b1;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 16'h4020;
    @(negedge clk);
    acc_addr = 16'h0000;
    check("R10 first wait cycle low", int'(ready), 0);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R10 phys unchanged", int'(phys_addr), ('hBA << 13) | 'h0020);
    check("R10 still waiting", int'(ready), 0);
    @(negedge clk);
    check("R10 ready at end", int'(ready), 1);
    check("R10 last ext cycle", int'(ext_en), 1);
    @(negedge clk);
    check("R10 no second access", int'(ext_en), 0);
    extra_wait_en = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 ready in reset", int'(ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_direct_write();
    t_extra();
    t_emu_regs();
    t_cart();
    t_bypass();
    t_busy();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule